// File: doc/BRIEF.md
# Omega Self-Routing Switch Fabric

This block is an N-by-N multistage switching fabric made of two-input, two-output switching elements arranged in log2 N stages of N/2 elements each. Every cycle each input port may present one tuple made of a valid bit, a broadcast flag, a destination tag and a data word. The tuples that enter together travel through the fabric as one wave, one stage per clock, and leave log2 N cycles later. Each tuple carries its own destination, so no central controller is needed. Every element sets itself from the tag bits of the packets in front of it.

Before every stage, including the first, the wiring rotates each line index left by one bit. This perfect shuffle is the same between every pair of stages. Element k of a stage takes lines 2k (upper) and 2k+1 (lower). Each element settles into one of four states: straight, crossover, upper-input broadcast or lower-input broadcast.

When two packets at one element need the same output, the upper one proceeds. The lower one is discarded, and a per-source blocked flag is raised in the cycle its wave leaves the fabric. A packet with the broadcast flag set is copied to both outputs of any element whose other input is idle. A packet alone in the fabric with the flag set therefore reaches every output.

Top module: `omega_fabric`

## Requirements
- R1: While reset is high, and in the cycle after it, every bit of `out_valid` and `out_blocked` is 0, even if packets were in flight.
- R2: A wave presented at the inputs before rising edge E appears at the outputs just after edge E+log2 N−1 (4 edges for N=16). No output is valid one edge earlier, and a new wave may enter on every cycle.
- R3: A unicast packet that is not blocked leaves on the output port whose index equals its destination tag. Its data word, its source port index on `out_src` and its tag on `out_dest` come with it.
- R4: Before each stage, line L moves to line rotl(L) over log2 N bits. Stage s steers by destination bit log2 N−1−s, where 0 selects the upper output and 1 the lower output. As a result, every cyclic-shift permutation (dest = (i+c) mod N) and every XOR permutation (dest = i xor c) passes with no packet blocked.
- R5: When both inputs of an element want the same output, the upper input wins and the lower packet is discarded. For N=16, input 0 and input 8 whose tags share the top bit collide in the first stage, and input 8 is lost. Input 0 and input 4 whose tags share the two top bits collide in the second stage, and input 4 is lost.
- R6: `out_blocked[i]` is high in the output cycle of the wave from which source i's packet was discarded, and only for sources that were valid. For a wave with no broadcast, the number of valid outputs plus the number of blocked flags equals the number of valid inputs.
- R7: A packet with `in_bcast` set is copied to both outputs of an element whose other input is idle. A broadcast packet that is alone in its wave reaches all N outputs, with its own source index and data on each.
- R8: At an element where both inputs are busy, a broadcast packet is steered by its tag bit like a unicast packet. For N=16, a broadcast from input 0 with tag 2 together with a unicast from input 8 with tag 9 delivers input 0 on outputs 0 to 7 and input 8 on output 9, and leaves every other output idle.
- R9: A port whose `in_valid` is 0 takes no part in routing, whatever its tag, broadcast flag and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_PORTS | Per-port packet present |
| in_bcast | input | N_PORTS | Per-port broadcast request |
| in_dest | input | N_PORTS*log2 N | Destination tag, port p in bits [p*log2 N +: log2 N] |
| in_data | input | N_PORTS*DATA_W | Data word, port p in bits [p*DATA_W +: DATA_W] |
| out_valid | output | N_PORTS | Per-output packet present |
| out_bcast | output | N_PORTS | Broadcast flag of the delivered packet |
| out_dest | output | N_PORTS*log2 N | Destination tag of the delivered packet |
| out_src | output | N_PORTS*log2 N | Source port index of the delivered packet |
| out_data | output | N_PORTS*DATA_W | Data word of the delivered packet |
| out_blocked | output | N_PORTS | Per-source flag: packet discarded in this wave |

## Verification
Within one wave, delivery of the winning packet and the discard of the losing packet happen at the same element in the same cycle. They must leave the fabric together: the winner on its port and the blocked flag on the loser's source bit. The bench provokes this with input pairs chosen to collide in the first stage and in the second stage. In each case it checks the winner's port, the loser's destination port left idle, and the exact blocked vector, all in one output cycle. Broadcast replication and unicast steering are made to meet at a shared first-stage element. The bench then judges that replication is withheld there and resumes only at the later, uncontested elements.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic [1:0] {
        SW_STRAIGHT = 2'd0,
        SW_CROSS    = 2'd1,
        SW_BC_UP    = 2'd2,
        SW_BC_LO    = 2'd3
    } sw_state_e;

    typedef struct packed {
        sw_state_e state;
        logic      drop_lo;
    } sw_ctl_t;

    // Element setting from the two inputs: valid, broadcast flag, steer bit.
    function automatic sw_ctl_t sw_decide(
        input logic vu, input logic bu, input logic su,
        input logic vl, input logic bl, input logic sl
    );
        sw_ctl_t c;
        c.state   = SW_STRAIGHT;
        c.drop_lo = 1'b0;
        if (vu && vl) begin
            c.state   = su ? SW_CROSS : SW_STRAIGHT;
            c.drop_lo = (su == sl);
        end else if (vu) begin
            if (bu)      c.state = SW_BC_UP;
            else if (su) c.state = SW_CROSS;
            else         c.state = SW_STRAIGHT;
        end else if (vl) begin
            if (bl)      c.state = SW_BC_LO;
            else if (sl) c.state = SW_STRAIGHT;
            else         c.state = SW_CROSS;
        end
        return c;
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int SEL_BIT = 3
) (
    input  logic [1:0]                                in_vld,
    input  logic [2*(1+2*ADDR_W+DATA_W)-1:0]          in_lane,
    output logic [1:0]                                out_vld,
    output logic [2*(1+2*ADDR_W+DATA_W)-1:0]          out_lane,
    output logic                                      drop_lo
);
    localparam int LANE_W  = 1 + 2*ADDR_W + DATA_W;
    localparam int BC_POS  = LANE_W - 1;
    localparam int STR_POS = DATA_W + ADDR_W + SEL_BIT;

    logic [LANE_W-1:0] up_l, lo_l;
    sw_ctl_t           ctl;

    assign up_l = in_lane[0 +: LANE_W];
    assign lo_l = in_lane[LANE_W +: LANE_W];

    assign ctl = sw_decide(in_vld[0], up_l[BC_POS], up_l[STR_POS],
                           in_vld[1], lo_l[BC_POS], lo_l[STR_POS]);
    assign drop_lo = ctl.drop_lo;

    always_comb begin
        out_lane = in_lane;
        out_vld  = in_vld;
        unique case (ctl.state)
            SW_STRAIGHT: begin
                out_lane = {lo_l, up_l};
                out_vld  = {in_vld[1] & ~ctl.drop_lo, in_vld[0]};
            end
            SW_CROSS: begin
                out_lane = {up_l, lo_l};
                out_vld  = {in_vld[0], in_vld[1] & ~ctl.drop_lo};
            end
            SW_BC_UP: begin
                out_lane = {up_l, up_l};
                out_vld  = {2{in_vld[0]}};
            end
            SW_BC_LO: begin
                out_lane = {lo_l, lo_l};
                out_vld  = {2{in_vld[1]}};
            end
            default: begin
                out_lane = in_lane;
                out_vld  = '0;
            end
        endcase
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
    parameter int N_PORTS = 16,
    parameter int DATA_W  = 8,
    parameter int STAGE   = 0
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [N_PORTS-1:0]                             in_vld,
    input  logic [N_PORTS*(1+2*$clog2(N_PORTS)+DATA_W)-1:0] in_lane,
    input  logic [N_PORTS-1:0]                             in_blk,
    output logic [N_PORTS-1:0]                             out_vld,
    output logic [N_PORTS*(1+2*$clog2(N_PORTS)+DATA_W)-1:0] out_lane,
    output logic [N_PORTS-1:0]                             out_blk
);
    localparam int ADDR_W  = $clog2(N_PORTS);
    localparam int LANE_W  = 1 + 2*ADDR_W + DATA_W;
    localparam int HALF    = N_PORTS / 2;
    localparam int SEL_BIT = ADDR_W - 1 - STAGE;

    logic [N_PORTS-1:0]        sh_vld;
    logic [N_PORTS*LANE_W-1:0] sh_lane;
    logic [N_PORTS-1:0]        sw_vld;
    logic [N_PORTS*LANE_W-1:0] sw_lane;
    logic [HALF-1:0]           sw_drop;
    logic [N_PORTS-1:0]        blk_nxt;

    // Perfect shuffle: line L moves to rotl(L).
    for (genvar l = 0; l < N_PORTS; l++) begin : g_shuffle
        localparam int P = ((l << 1) | (l >> (ADDR_W - 1))) & (N_PORTS - 1);
        assign sh_vld[P]                  = in_vld[l];
        assign sh_lane[P*LANE_W +: LANE_W] = in_lane[l*LANE_W +: LANE_W];
    end

    for (genvar k = 0; k < HALF; k++) begin : g_elem
        omega_switch #(
            .DATA_W  (DATA_W),
            .ADDR_W  (ADDR_W),
            .SEL_BIT (SEL_BIT)
        ) u_sw (
            .in_vld   (sh_vld[2*k +: 2]),
            .in_lane  (sh_lane[2*k*LANE_W +: 2*LANE_W]),
            .out_vld  (sw_vld[2*k +: 2]),
            .out_lane (sw_lane[2*k*LANE_W +: 2*LANE_W]),
            .drop_lo  (sw_drop[k])
        );
    end

    always_comb begin
        blk_nxt = in_blk;
        for (int k = 0; k < HALF; k++) begin
            if (sw_drop[k]) begin
                blk_nxt[sh_lane[(2*k+1)*LANE_W + DATA_W +: ADDR_W]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= '0;
            out_blk  <= '0;
            out_lane <= '0;
        end else begin
            out_vld  <= sw_vld;
            out_blk  <= blk_nxt;
            out_lane <= sw_lane;
        end
    end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
    parameter int N_PORTS = 16,
    parameter int DATA_W  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [N_PORTS-1:0]                   in_valid,
    input  logic [N_PORTS-1:0]                   in_bcast,
    input  logic [N_PORTS*$clog2(N_PORTS)-1:0]   in_dest,
    input  logic [N_PORTS*DATA_W-1:0]            in_data,
    output logic [N_PORTS-1:0]                   out_valid,
    output logic [N_PORTS-1:0]                   out_bcast,
    output logic [N_PORTS*$clog2(N_PORTS)-1:0]   out_dest,
    output logic [N_PORTS*$clog2(N_PORTS)-1:0]   out_src,
    output logic [N_PORTS*DATA_W-1:0]            out_data,
    output logic [N_PORTS-1:0]                   out_blocked
);
    localparam int ADDR_W = $clog2(N_PORTS);
    localparam int LANE_W = 1 + 2*ADDR_W + DATA_W;
    localparam int STAGES = ADDR_W;

    logic [N_PORTS-1:0]        c_vld  [STAGES+1];
    logic [N_PORTS*LANE_W-1:0] c_lane [STAGES+1];
    logic [N_PORTS-1:0]        c_blk  [STAGES+1];

    assign c_vld[0] = in_valid;
    assign c_blk[0] = '0;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_pack
        assign c_lane[0][p*LANE_W +: LANE_W] = {in_bcast[p],
                                                in_dest[p*ADDR_W +: ADDR_W],
                                                ADDR_W'(p),
                                                in_data[p*DATA_W +: DATA_W]};
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        omega_stage #(
            .N_PORTS (N_PORTS),
            .DATA_W  (DATA_W),
            .STAGE   (s)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (c_vld[s]),
            .in_lane  (c_lane[s]),
            .in_blk   (c_blk[s]),
            .out_vld  (c_vld[s+1]),
            .out_lane (c_lane[s+1]),
            .out_blk  (c_blk[s+1])
        );
    end

    assign out_valid   = c_vld[STAGES];
    assign out_blocked = c_blk[STAGES];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_unpack
        assign out_data[p*DATA_W +: DATA_W] = c_lane[STAGES][p*LANE_W +: DATA_W];
        assign out_src[p*ADDR_W +: ADDR_W]  = c_lane[STAGES][p*LANE_W + DATA_W +: ADDR_W];
        assign out_dest[p*ADDR_W +: ADDR_W] = c_lane[STAGES][p*LANE_W + DATA_W + ADDR_W +: ADDR_W];
        assign out_bcast[p]                 = c_lane[STAGES][p*LANE_W + LANE_W - 1];
    end

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
    parameter int N_PORTS = 16,
    parameter int DATA_W  = 8
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic [N_PORTS-1:0]                   in_valid,
    input logic [N_PORTS-1:0]                   in_bcast,
    input logic [N_PORTS-1:0]                   out_valid,
    input logic [N_PORTS-1:0]                   out_bcast,
    input logic [N_PORTS*$clog2(N_PORTS)-1:0]   out_dest,
    input logic [N_PORTS-1:0]                   out_blocked
);
    localparam int ADDR_W = $clog2(N_PORTS);
    localparam int STAGES = ADDR_W;

    logic [N_PORTS-1:0] h_vld [STAGES];
    logic [N_PORTS-1:0] h_bc  [STAGES];
    logic [N_PORTS-1:0] w_vld;
    logic               w_anybc;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                h_vld[s] <= '0;
                h_bc[s]  <= '0;
            end
        end else begin
            h_vld[0] <= in_valid;
            h_bc[0]  <= in_valid & in_bcast;
            for (int s = 1; s < STAGES; s++) begin
                h_vld[s] <= h_vld[s-1];
                h_bc[s]  <= h_bc[s-1];
            end
        end
    end

    assign w_vld   = h_vld[STAGES-1];
    assign w_anybc = |h_bc[STAGES-1];

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && out_blocked == '0));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> (|w_vld));

    p_conserve_r6: assert property (@(posedge clk) disable iff (rst)
        !w_anybc |-> ($countones(out_valid) + $countones(out_blocked) == $countones(w_vld)));

    p_blk_only_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (out_blocked & ~w_vld) == '0);

    p_lone_bcast_r7: assert property (@(posedge clk) disable iff (rst)
        ($countones(w_vld) == 1 && w_anybc) |-> (&out_valid && out_blocked == '0));

    for (genvar j = 0; j < N_PORTS; j++) begin : g_port
        p_dest_match_r3: assert property (@(posedge clk) disable iff (rst)
            (out_valid[j] && !out_bcast[j]) |-> (out_dest[j*ADDR_W +: ADDR_W] == ADDR_W'(j)));
    end

endmodule

bind omega_fabric omega_fabric_chk #(
    .N_PORTS (N_PORTS),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_bcast    (in_bcast),
    .out_valid   (out_valid),
    .out_bcast   (out_bcast),
    .out_dest    (out_dest),
    .out_blocked (out_blocked)
);

// File: tb/omega_fabric_bench.sv
`timescale 1ns/100ps
module omega_fabric_bench;
    localparam int N  = 16;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int LAT = 4;

    // {mode, const}: mode 0 = cyclic shift by const, mode 1 = xor with const
    localparam logic [4:0] WAVES [8] = '{
        5'b0_0000, 5'b0_0001, 5'b0_0101, 5'b0_1111,
        5'b1_0001, 5'b1_1000, 5'b1_1111, 5'b1_0110
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      in_valid = '0;
    logic [N-1:0]      in_bcast = '0;
    logic [N*AW-1:0]   in_dest  = '0;
    logic [N*DW-1:0]   in_data  = '0;
    logic [N-1:0]      out_valid;
    logic [N-1:0]      out_bcast;
    logic [N*AW-1:0]   out_dest;
    logic [N*AW-1:0]   out_src;
    logic [N*DW-1:0]   out_data;
    logic [N-1:0]      out_blocked;

    int n_tests = 0;
    int n_fail  = 0;

    logic         exp_v [N];
    int           exp_s [N];
    int           exp_d [N];
    logic [N-1:0] exp_blk;

    always #2.5 clk = ~clk;

    omega_fabric #(.N_PORTS(N), .DATA_W(DW)) u_omega_fabric (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_bcast(in_bcast), .in_dest(in_dest), .in_data(in_data),
        .out_valid(out_valid), .out_bcast(out_bcast), .out_dest(out_dest),
        .out_src(out_src), .out_data(out_data), .out_blocked(out_blocked)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        in_valid = '0; in_bcast = '0; in_dest = '0; in_data = '0;
    endtask

    task automatic put(input int p, input int dest, input logic bc, input int data);
        in_valid[p] = 1'b1;
        in_bcast[p] = bc;
        in_dest[p*AW +: AW] = AW'(dest);
        in_data[p*DW +: DW] = DW'(data);
    endtask

    task automatic clear_expect();
        for (int j = 0; j < N; j++) begin
            exp_v[j] = 1'b0; exp_s[j] = 0; exp_d[j] = 0;
        end
        exp_blk = '0;
    endtask

    task automatic expect_at(input int j, input int src, input int data);
        exp_v[j] = 1'b1; exp_s[j] = src; exp_d[j] = data;
    endtask

    task automatic verify(input string req);
        for (int j = 0; j < N; j++) begin
            check(req, $sformatf("valid[%0d]", j), longint'(out_valid[j]), longint'(exp_v[j]));
            if (exp_v[j]) begin
                check(req, $sformatf("src[%0d]", j), longint'(out_src[j*AW +: AW]), longint'(exp_s[j]));
                check(req, $sformatf("data[%0d]", j), longint'(out_data[j*DW +: DW]), longint'(exp_d[j]));
            end
        end
        check(req, "blocked", longint'(out_blocked), longint'(exp_blk));
    endtask

    // Inputs are set at a falling edge; the wave is launched at the next rising edge.
    task automatic launch_and_wait();
        @(negedge clk);
        clear_inputs();
        repeat (LAT-1) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", longint'(out_valid), 0);
        check("R1", "blocked in reset", longint'(out_blocked), 0);
        rst = 1'b0;
        @(negedge clk);

        // R3 / R4: table of admissible permutations
        for (int w = 0; w < 8; w++) begin
            clear_expect();
            for (int i = 0; i < N; i++) begin
                int d;
                d = WAVES[w][4] ? (i ^ int'(WAVES[w][3:0])) : ((i + int'(WAVES[w][3:0])) % N);
                put(i, d, 1'b0, (i << 4) | w);
                expect_at(d, i, (i << 4) | w);
            end
            launch_and_wait();
            verify(WAVES[w][4] ? "R4 xor perm R3" : "R4 shift perm R3");
            @(negedge clk);
        end

        // R2: latency and back-to-back waves
        clear_expect();
        for (int i = 0; i < N; i++) put(i, (i + 1) % N, 1'b0, 8'h10 + i);
        @(negedge clk);
        clear_inputs();
        for (int i = 0; i < N; i++) put(i, i ^ 5, 1'b0, 8'h60 + i);
        @(negedge clk);
        clear_inputs();
        @(negedge clk);
        check("R2", "valid one edge early", longint'(out_valid), 0);
        @(negedge clk);
        for (int i = 0; i < N; i++) expect_at((i + 1) % N, i, 8'h10 + i);
        verify("R2 first wave");
        @(negedge clk);
        clear_expect();
        for (int i = 0; i < N; i++) expect_at(i ^ 5, i, 8'h60 + i);
        verify("R2 second wave");
        @(negedge clk);
        check("R2", "drained", longint'(out_valid), 0);

        // R5: first-stage conflict, inputs 0 and 8
        clear_expect();
        put(0, 3, 1'b0, 8'hA0);
        put(8, 5, 1'b0, 8'hA8);
        expect_at(3, 0, 8'hA0);
        exp_blk = 16'h0100;
        launch_and_wait();
        verify("R5 stage0 conflict R6");
        @(negedge clk);

        // R5: second-stage conflict, inputs 0 and 4
        clear_expect();
        put(0, 0, 1'b0, 8'hB0);
        put(4, 1, 1'b0, 8'hB4);
        put(7, 13, 1'b0, 8'hB7);
        expect_at(0, 0, 8'hB0);
        expect_at(13, 7, 8'hB7);
        exp_blk = 16'h0010;
        launch_and_wait();
        verify("R5 stage1 conflict R6");
        @(negedge clk);

        // R7: lone broadcast
        clear_expect();
        put(5, 0, 1'b1, 8'hC5);
        for (int j = 0; j < N; j++) expect_at(j, 5, 8'hC5);
        launch_and_wait();
        verify("R7 lone broadcast");
        @(negedge clk);

        // R8: broadcast meets a busy partner in the first stage
        clear_expect();
        put(0, 2, 1'b1, 8'hD0);
        put(8, 9, 1'b0, 8'hD8);
        for (int j = 0; j < 8; j++) expect_at(j, 0, 8'hD0);
        expect_at(9, 8, 8'hD8);
        launch_and_wait();
        verify("R8 contested broadcast");
        @(negedge clk);

        // R9: invalid ports are ignored
        clear_expect();
        in_bcast[3] = 1'b1; in_dest[3*AW +: AW] = 4'd7; in_data[3*DW +: DW] = 8'hEE;
        in_bcast[8] = 1'b0; in_dest[8*AW +: AW] = 4'd6; in_data[8*DW +: DW] = 8'hEF;
        put(0, 6, 1'b0, 8'hE0);
        expect_at(6, 0, 8'hE0);
        launch_and_wait();
        verify("R9 invalid ignored");
        @(negedge clk);

        // R1: reset with a wave in flight
        for (int i = 0; i < N; i++) put(i, i, 1'b0, i);
        @(negedge clk);
        clear_inputs();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "valid after reset", longint'(out_valid), 0);
        check("R1", "blocked after reset", longint'(out_blocked), 0);
        repeat (LAT) @(negedge clk);
        check("R1", "flushed wave stays gone", longint'(out_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule